// File: doc/BRIEF.md
# Configurable Logic Slice

A parameterized model of one programmable logic slice: two 4-input lookup tables and two storage elements. A loaded configuration selects the arithmetic arrangement of the tables and the behaviour of each storage element. The tables can evaluate two independent functions, which doubles as two 16×1 read-only tables. They can act as a 2-bit full-adder stage that takes a carry from the previous slice and passes one to the next. They can also merge into one 5-input function, with a select input choosing between the two table outputs.

Each storage element sits behind one table output. It can be a plain wire, an edge-triggered register or a transparent latch. Its active clock edge or level is selectable, it has a clock enable, and it has a set/reset that forces either 1 or 0. That set/reset can act only with the clock or at once. Configuration is captured only when a load strobe is high. A build parameter removes the storage elements to give the reduced slice that has tables only.

Top module: `logic_slice`

## Requirements
- R1: While rst_n is low, the configuration is cleared: logic mode, both masks zero, both storage kinds bypass, rising polarity, synchronous set/reset, reset value 0. Every storage element is cleared to 0. With that configuration f, q and cout are 0.
- R2: The cfg_* inputs are captured on a rising clk edge only when cfg_load is 1. At any other time, changes on them have no effect on f, q or cout.
- R3: In mode 2'b00 (logic) or 2'b11 (read-only table), f[i] equals bit k of mask i, where k is the unsigned value of lut_in_i with bit 3 as the most significant bit.
- R4: In mode 2'b01 (ripple), {cout, f[1], f[0]} equals {lut_in1[0], lut_in0[0]} + {lut_in1[1], lut_in0[1]} + cin. Both masks and lut_in bits 3:2 are ignored.
- R5: In every mode other than ripple, cout is 0.
- R6: In mode 2'b10 (combine), both tables are addressed by lut_in0. f[0] is mask 1 at that address when sel5 is 1 and mask 0 at that address when sel5 is 0. f[1] is mask 1 at that address.
- R7: Storage kind 2'b00 or 2'b11 (bits [2i+1:2i] of cfg_kind) is bypass: q[i] equals f[i] at all times.
- R8: Storage kind 2'b01 is a register. If cfg_neg[i] is 0 it captures f[i] on the rising clk edge, and if 1 on the falling edge, but only when ce is 1. When ce is 0 it holds.
- R9: Storage kind 2'b10 is a latch. It follows f[i] while clk is high (cfg_neg[i] = 0) or low (cfg_neg[i] = 1) and ce is 1. Otherwise it holds.
- R10: When cfg_async[i] is 0, lsr acts only at the active edge (register) or during the open level (latch). There it loads cfg_setval[i] into storage element i, taking priority over ce.
- R11: When cfg_async[i] is 1, lsr high forces storage element i to cfg_setval[i] at once, whatever the state of clk.
- R12: With HAS_STORAGE = 0, q equals f at all times, whatever the storage configuration, ce or lsr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slice clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Configuration capture strobe |
| cfg_mode | input | 2 | Table mode: 00 logic, 01 ripple, 10 combine, 11 read-only table |
| cfg_mask0 | input | 16 | Truth table of lookup table 0 |
| cfg_mask1 | input | 16 | Truth table of lookup table 1 |
| cfg_kind | input | 4 | Storage kind per element, 2 bits each |
| cfg_neg | input | 2 | Per element: 1 selects falling edge / low level |
| cfg_async | input | 2 | Per element: 1 makes set/reset asynchronous |
| cfg_setval | input | 2 | Per element: value forced by set/reset |
| lut_in0 | input | 4 | Address of lookup table 0 |
| lut_in1 | input | 4 | Address of lookup table 1 |
| sel5 | input | 1 | Fifth input in combine mode |
| cin | input | 1 | Carry from the previous slice |
| ce | input | 1 | Storage clock enable |
| lsr | input | 1 | Storage set/reset request |
| f | output | 2 | Combinational table outputs |
| q | output | 2 | Storage element outputs |
| cout | output | 1 | Carry to the next slice |

## Verification
The properties assume that the lookup inputs, cin, sel5, ce and lsr change only away from the rising clk edge. That way the values sampled at the edge equal the settled combinational outputs. They also assume that the configuration changes only through a strobed capture, and that lsr does not rise between edges while a synchronous register is being checked for holding. The stimulus drives every input a fraction of a period after a clock edge and never at an edge. Clock-enable hold and edge-forcing are checked only for the rising-edge register form, and the falling-edge and latch forms are left to the directed tests.

// File: rtl/slice_pkg.sv
`timescale 1ns/1ps
package slice_pkg;
  localparam int LUT_K   = 4;
  localparam int MASK_W  = 1 << LUT_K;
  localparam int NUM_LUT = 2;

  typedef enum logic [1:0] {
    MODE_LOGIC   = 2'b00,
    MODE_RIPPLE  = 2'b01,
    MODE_COMBINE = 2'b10,
    MODE_ROM     = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    ST_BYPASS = 2'b00,
    ST_FLOP   = 2'b01,
    ST_LATCH  = 2'b10,
    ST_WIRE   = 2'b11
  } kind_e;

  typedef struct packed {
    kind_e kind;
    logic  neg;
    logic  sr_async;
    logic  sr_value;
  } store_cfg_t;

  typedef struct packed {
    mode_e                            mode;
    logic [NUM_LUT-1:0][MASK_W-1:0]   mask;
    store_cfg_t [NUM_LUT-1:0]         st;
  } slice_cfg_t;

  // one-bit read of a truth table
  function automatic logic lut_read(input logic [MASK_W-1:0] mask,
                                    input logic [LUT_K-1:0]  idx);
    return mask[idx];
  endfunction

  // bitwise ripple addition, carry out in the top bit
  function automatic logic [NUM_LUT:0] ripple_add(input logic [NUM_LUT-1:0] a,
                                                  input logic [NUM_LUT-1:0] b,
                                                  input logic               c_in);
    logic [NUM_LUT:0] r;
    logic             c;
    c = c_in;
    for (int i = 0; i < NUM_LUT; i++) begin
      r[i] = a[i] ^ b[i] ^ c;
      c    = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
    end
    r[NUM_LUT] = c;
    return r;
  endfunction
endpackage

// File: rtl/slice_lut.sv
`timescale 1ns/1ps
module slice_lut
  import slice_pkg::*;
(
  input  logic [MASK_W-1:0] mask,
  input  logic [LUT_K-1:0]  idx,
  output logic              y
);
  assign y = lut_read(mask, idx);
endmodule

// File: rtl/slice_carry.sv
`timescale 1ns/1ps
module slice_carry
  import slice_pkg::*;
(
  input  logic [NUM_LUT-1:0] a,
  input  logic [NUM_LUT-1:0] b,
  input  logic               c_in,
  output logic [NUM_LUT-1:0] sum,
  output logic               c_out
);
  logic [NUM_LUT:0] total;
  assign total = ripple_add(a, b, c_in);
  assign sum   = total[NUM_LUT-1:0];
  assign c_out = total[NUM_LUT];
endmodule

// File: rtl/slice_store.sv
`timescale 1ns/1ps
module slice_store
  import slice_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  store_cfg_t cfg,
  input  logic       d,
  input  logic       ce,
  input  logic       lsr,
  output logic       q
);
  logic clk_eff;
  logic force_now;
  logic level_open;
  logic q_flop;
  logic q_latch;

  assign clk_eff    = clk ^ cfg.neg;
  assign force_now  = lsr & cfg.sr_async;
  assign level_open = clk_eff;

  always_ff @(posedge clk_eff or posedge force_now or negedge rst_n) begin
    if (!rst_n)         q_flop <= 1'b0;
    else if (force_now) q_flop <= cfg.sr_value;
    else if (lsr)       q_flop <= cfg.sr_value;
    else if (ce)        q_flop <= d;
  end

  always_latch begin
    if (!rst_n)         q_latch <= 1'b0;
    else if (force_now) q_latch <= cfg.sr_value;
    else if (level_open) begin
      if (lsr)     q_latch <= cfg.sr_value;
      else if (ce) q_latch <= d;
    end
  end

  always_comb begin
    case (cfg.kind)
      ST_FLOP:  q = q_flop;
      ST_LATCH: q = q_latch;
      default:  q = d;
    endcase
  end
endmodule

// File: rtl/logic_slice.sv
`timescale 1ns/1ps
module logic_slice
  import slice_pkg::*;
#(
  parameter int HAS_STORAGE = 1
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_load,
  input  logic [1:0]            cfg_mode,
  input  logic [MASK_W-1:0]     cfg_mask0,
  input  logic [MASK_W-1:0]     cfg_mask1,
  input  logic [2*NUM_LUT-1:0]  cfg_kind,
  input  logic [NUM_LUT-1:0]    cfg_neg,
  input  logic [NUM_LUT-1:0]    cfg_async,
  input  logic [NUM_LUT-1:0]    cfg_setval,
  input  logic [LUT_K-1:0]      lut_in0,
  input  logic [LUT_K-1:0]      lut_in1,
  input  logic                  sel5,
  input  logic                  cin,
  input  logic                  ce,
  input  logic                  lsr,
  output logic [NUM_LUT-1:0]    f,
  output logic [NUM_LUT-1:0]    q,
  output logic                  cout
);
  slice_cfg_t cfg_d, cfg_q;

  always_comb begin
    cfg_d.mode    = mode_e'(cfg_mode);
    cfg_d.mask[0] = cfg_mask0;
    cfg_d.mask[1] = cfg_mask1;
    for (int i = 0; i < NUM_LUT; i++) begin
      cfg_d.st[i].kind     = kind_e'(cfg_kind[2*i +: 2]);
      cfg_d.st[i].neg      = cfg_neg[i];
      cfg_d.st[i].sr_async = cfg_async[i];
      cfg_d.st[i].sr_value = cfg_setval[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfg_q <= '0;
    else if (cfg_load) cfg_q <= cfg_d;
  end

  // named views of the live configuration for the checker
  logic [1:0]           cur_mode;
  logic [2*NUM_LUT-1:0] cur_kind;
  logic [NUM_LUT-1:0]   cur_neg, cur_async, cur_setval;
  logic                 store_on;
  assign cur_mode = cfg_q.mode;
  assign store_on = (HAS_STORAGE != 0);

  logic [NUM_LUT-1:0][LUT_K-1:0] pin_addr;
  logic [NUM_LUT-1:0][LUT_K-1:0] lut_addr;
  logic [NUM_LUT-1:0]            lut_y;
  logic                          combine_on;
  assign pin_addr   = {lut_in1, lut_in0};
  assign combine_on = (cfg_q.mode == MODE_COMBINE);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_LUT; gi++) begin : g_lut
      assign cur_kind[2*gi +: 2] = cfg_q.st[gi].kind;
      assign cur_neg[gi]         = cfg_q.st[gi].neg;
      assign cur_async[gi]       = cfg_q.st[gi].sr_async;
      assign cur_setval[gi]      = cfg_q.st[gi].sr_value;
      assign lut_addr[gi]        = combine_on ? pin_addr[0] : pin_addr[gi];
      slice_lut u_lut (
        .mask (cfg_q.mask[gi]),
        .idx  (lut_addr[gi]),
        .y    (lut_y[gi])
      );
    end
  endgenerate

  logic [NUM_LUT-1:0] add_a, add_b, rip_sum;
  logic               rip_cout;
  assign add_a = {lut_in1[0], lut_in0[0]};
  assign add_b = {lut_in1[1], lut_in0[1]};

  slice_carry u_carry (
    .a     (add_a),
    .b     (add_b),
    .c_in  (cin),
    .sum   (rip_sum),
    .c_out (rip_cout)
  );

  always_comb begin
    f    = lut_y;
    cout = 1'b0;
    case (cfg_q.mode)
      MODE_RIPPLE: begin
        f    = rip_sum;
        cout = rip_cout;
      end
      MODE_COMBINE: begin
        f[0] = sel5 ? lut_y[1] : lut_y[0];
        f[1] = lut_y[1];
      end
      default: ;
    endcase
  end

  generate
    if (HAS_STORAGE != 0) begin : g_store
      for (gi = 0; gi < NUM_LUT; gi++) begin : g_el
        slice_store u_st (
          .clk   (clk),
          .rst_n (rst_n),
          .cfg   (cfg_q.st[gi]),
          .d     (f[gi]),
          .ce    (ce),
          .lsr   (lsr),
          .q     (q[gi])
        );
      end
    end else begin : g_nostore
      assign q = f;
    end
  endgenerate
endmodule

// File: rtl/slice_checker.sv
`timescale 1ns/1ps
module slice_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_load,
  input logic [3:0] lut_in0,
  input logic [3:0] lut_in1,
  input logic       cin,
  input logic       ce,
  input logic       lsr,
  input logic [1:0] f,
  input logic [1:0] q,
  input logic       cout,
  input logic [1:0] cur_mode,
  input logic [3:0] cur_kind,
  input logic [1:0] cur_neg,
  input logic [1:0] cur_async,
  input logic [1:0] cur_setval,
  input logic       store_on
);
  logic [2:0] add_ref;
  assign add_ref = {1'b0, lut_in1[0], lut_in0[0]} + {1'b0, lut_in1[1], lut_in0[1]} + {2'b00, cin};

  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> ($stable(cur_mode) && $stable(cur_kind) && $stable(cur_setval)));

  assert_ripple_sum_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == 2'b01) |-> ({cout, f} == add_ref));

  assert_cout_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode != 2'b01) |-> !cout);

  assert_bypass0_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_kind[1:0] == 2'b00 || cur_kind[1:0] == 2'b11) |-> (q[0] == f[0]));

  assert_bypass1_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_kind[3:2] == 2'b00 || cur_kind[3:2] == 2'b11) |-> (q[1] == f[1]));

  assert_ce_hold0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (store_on && cur_kind[1:0] == 2'b01 && !cur_neg[0] && !cur_async[0] && !lsr && !ce && !cfg_load)
      |=> $stable(q[0]));

  assert_sync_force0_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (store_on && cur_kind[1:0] == 2'b01 && !cur_neg[0] && !cur_async[0] && lsr && !cfg_load)
      |=> (q[0] == $past(cur_setval[0])));

  assert_sync_force1_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (store_on && cur_kind[3:2] == 2'b01 && !cur_neg[1] && !cur_async[1] && lsr && !cfg_load)
      |=> (q[1] == $past(cur_setval[1])));

  assert_async_force0_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (store_on && (cur_kind[1:0] == 2'b01 || cur_kind[1:0] == 2'b10) && cur_async[0] && lsr)
      |-> (q[0] == cur_setval[0]));

  assert_async_force1_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (store_on && (cur_kind[3:2] == 2'b01 || cur_kind[3:2] == 2'b10) && cur_async[1] && lsr)
      |-> (q[1] == cur_setval[1]));

  assert_reduced_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !store_on |-> (q == f));
endmodule

bind logic_slice slice_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_load   (cfg_load),
  .lut_in0    (lut_in0),
  .lut_in1    (lut_in1),
  .cin        (cin),
  .ce         (ce),
  .lsr        (lsr),
  .f          (f),
  .q          (q),
  .cout       (cout),
  .cur_mode   (cur_mode),
  .cur_kind   (cur_kind),
  .cur_neg    (cur_neg),
  .cur_async  (cur_async),
  .cur_setval (cur_setval),
  .store_on   (store_on)
);

// File: tb/sim_logic_slice.sv
`timescale 1ns/1ps
module sim_logic_slice;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_load;
  logic [1:0]  cfg_mode;
  logic [15:0] cfg_mask0, cfg_mask1;
  logic [3:0]  cfg_kind;
  logic [1:0]  cfg_neg, cfg_async, cfg_setval;
  logic [3:0]  lut_in0, lut_in1;
  logic        sel5, cin, ce, lsr;
  logic [1:0]  f, q, f_r, q_r;
  logic        cout, cout_r;

  int tests  = 0;
  int failed = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  logic_slice u0 (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mode(cfg_mode),
    .cfg_mask0(cfg_mask0), .cfg_mask1(cfg_mask1), .cfg_kind(cfg_kind),
    .cfg_neg(cfg_neg), .cfg_async(cfg_async), .cfg_setval(cfg_setval),
    .lut_in0(lut_in0), .lut_in1(lut_in1), .sel5(sel5), .cin(cin),
    .ce(ce), .lsr(lsr), .f(f), .q(q), .cout(cout)
  );

  logic_slice #(.HAS_STORAGE(0)) u1 (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mode(cfg_mode),
    .cfg_mask0(cfg_mask0), .cfg_mask1(cfg_mask1), .cfg_kind(cfg_kind),
    .cfg_neg(cfg_neg), .cfg_async(cfg_async), .cfg_setval(cfg_setval),
    .lut_in0(lut_in0), .lut_in1(lut_in1), .sel5(sel5), .cin(cin),
    .ce(ce), .lsr(lsr), .f(f_r), .q(q_r), .cout(cout_r)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic load_cfg(input logic [1:0] mode, input logic [15:0] m0, input logic [15:0] m1,
                          input logic [3:0] kind, input logic [1:0] neg,
                          input logic [1:0] asy, input logic [1:0] setv);
    cfg_mode = mode; cfg_mask0 = m0; cfg_mask1 = m1; cfg_kind = kind;
    cfg_neg = neg; cfg_async = asy; cfg_setval = setv;
    cfg_load = 1'b1;
    step();
    cfg_load = 1'b0;
  endtask

  function automatic logic bit_of(input logic [15:0] m, input logic [3:0] k);
    return logic'((m >> k) & 16'h1);
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; cfg_load = 1'b1; cfg_mode = 2'b01; cfg_mask0 = 16'hFFFF; cfg_mask1 = 16'hFFFF;
    cfg_kind = 4'b0101; cfg_neg = 2'b00; cfg_async = 2'b00; cfg_setval = 2'b11;
    lut_in0 = 4'hF; lut_in1 = 4'hF; sel5 = 1'b0; cin = 1'b1; ce = 1'b1; lsr = 1'b0;
    repeat (3) step();
    chk("R1 reset f", {6'b0, f}, 8'h00);
    chk("R1 reset q", {6'b0, q}, 8'h00);
    chk("R1 reset cout", {7'b0, cout}, 8'h00);
    cfg_load = 1'b0;
    rst_n = 1'b1;
    step();
    chk("R1 after release f", {6'b0, f}, 8'h00);
  endtask

  task automatic t_load_strobe();
    load_cfg(2'b00, 16'hAAAA, 16'hAAAA, 4'b0000, 2'b00, 2'b00, 2'b00);
    lut_in0 = 4'h1; lut_in1 = 4'h0; cin = 1'b1;
    #0.5;
    chk("R2 loaded f", {6'b0, f}, 8'h01);
    cfg_mask0 = 16'h0000; cfg_mode = 2'b01; cfg_kind = 4'b0101;
    step(); step();
    chk("R2 unstrobed f", {6'b0, f}, 8'h01);
    chk("R2 unstrobed cout", {7'b0, cout}, 8'h00);
    cfg_load = 1'b1; step(); cfg_load = 1'b0;
    cfg_mode = 2'b00; cfg_kind = 4'b0000;
    #0.5;
    chk("R2 strobed ripple f", {5'b0, cout, f}, 8'h02);
  endtask

  task automatic t_rom();
    load_cfg(2'b11, 16'hA5C3, 16'h3C96, 4'b0000, 2'b00, 2'b00, 2'b00);
    for (int k = 0; k < 16; k++) begin
      lut_in0 = 4'(k); lut_in1 = 4'(15 - k);
      #1;
      chk("R3 rom f0", {7'b0, f[0]}, {7'b0, bit_of(16'hA5C3, 4'(k))});
      chk("R3 rom f1", {7'b0, f[1]}, {7'b0, bit_of(16'h3C96, 4'(15 - k))});
    end
    load_cfg(2'b00, 16'h8001, 16'h7FFE, 4'b0000, 2'b00, 2'b00, 2'b00);
    lut_in0 = 4'hF; lut_in1 = 4'h0;
    #1;
    chk("R3 logic corners", {6'b0, f}, 8'h01);
    lut_in0 = 4'h7; lut_in1 = 4'h7;
    #1;
    chk("R3 logic mid", {6'b0, f}, 8'h02);
  endtask

  task automatic t_ripple();
    load_cfg(2'b01, 16'hFFFF, 16'h0000, 4'b0000, 2'b00, 2'b00, 2'b00);
    for (int v = 0; v < 32; v++) begin
      logic [4:0] b;
      logic [2:0] expv;
      b = 5'(v);
      lut_in0 = {2'b10, b[1], b[0]};
      lut_in1 = {2'b01, b[3], b[2]};
      cin = b[4];
      expv = 3'({b[2], b[0]}) + 3'({b[3], b[1]}) + 3'(b[4]);
      #1;
      chk("R4 ripple sum", {5'b0, cout, f}, {5'b0, expv});
    end
  endtask

  task automatic t_cout_idle();
    load_cfg(2'b00, 16'hFFFF, 16'hFFFF, 4'b0000, 2'b00, 2'b00, 2'b00);
    lut_in0 = 4'h3; lut_in1 = 4'h3; cin = 1'b1;
    #1;
    chk("R5 logic cout", {7'b0, cout}, 8'h00);
    load_cfg(2'b10, 16'hFFFF, 16'hFFFF, 4'b0000, 2'b00, 2'b00, 2'b00);
    #1;
    chk("R5 combine cout", {7'b0, cout}, 8'h00);
  endtask

  task automatic t_combine();
    load_cfg(2'b10, 16'h00FF, 16'hF0F0, 4'b0000, 2'b00, 2'b00, 2'b00);
    for (int k = 0; k < 16; k++) begin
      for (int s = 0; s < 2; s++) begin
        lut_in0 = 4'(k); lut_in1 = ~4'(k); sel5 = s[0];
        #1;
        chk("R6 combine f0", {7'b0, f[0]},
            {7'b0, s[0] ? bit_of(16'hF0F0, 4'(k)) : bit_of(16'h00FF, 4'(k))});
        chk("R6 combine f1", {7'b0, f[1]}, {7'b0, bit_of(16'hF0F0, 4'(k))});
      end
    end
    sel5 = 1'b0;
  endtask

  task automatic t_bypass();
    load_cfg(2'b00, 16'hAAAA, 16'hAAAA, 4'b1100, 2'b00, 2'b00, 2'b00);
    ce = 1'b0;
    lut_in0 = 4'h1; lut_in1 = 4'h0;
    #0.5;
    chk("R7 bypass q", {6'b0, q}, 8'h01);
    lut_in0 = 4'h0; lut_in1 = 4'h1;
    #0.5;
    chk("R7 bypass q swap", {6'b0, q}, 8'h02);
    ce = 1'b1;
  endtask

  task automatic t_flop_pos();
    load_cfg(2'b00, 16'hAAAA, 16'hAAAA, 4'b0101, 2'b00, 2'b00, 2'b00);
    ce = 1'b1; lut_in0 = 4'h0; lut_in1 = 4'h0;
    step();
    chk("R8 flop base", {6'b0, q}, 8'h00);
    lut_in0 = 4'h1;
    #0.5;
    chk("R8 flop before edge", {6'b0, q}, 8'h00);
    step();
    chk("R8 flop captured", {6'b0, q}, 8'h01);
    ce = 1'b0; lut_in0 = 4'h0; lut_in1 = 4'h1;
    step();
    chk("R8 flop ce hold", {6'b0, q}, 8'h01);
    ce = 1'b1;
    step();
    chk("R8 flop ce resumed", {6'b0, q}, 8'h02);
  endtask

  task automatic t_flop_neg();
    load_cfg(2'b00, 16'hAAAA, 16'hAAAA, 4'b0101, 2'b11, 2'b00, 2'b00);
    ce = 1'b1; lut_in0 = 4'h0; lut_in1 = 4'h0;
    @(negedge clk); #1;
    chk("R8 neg base", {6'b0, q}, 8'h00);
    lut_in0 = 4'h1; lut_in1 = 4'h1;
    step();
    chk("R8 neg ignores rise", {6'b0, q}, 8'h00);
    @(negedge clk); #1;
    chk("R8 neg captured on fall", {6'b0, q}, 8'h03);
  endtask

  task automatic t_latch();
    load_cfg(2'b00, 16'hAAAA, 16'hAAAA, 4'b1010, 2'b00, 2'b00, 2'b00);
    ce = 1'b1;
    @(posedge clk); #0.5;
    lut_in0 = 4'h1; lut_in1 = 4'h1;
    #0.5;
    chk("R9 latch open high", {6'b0, q}, 8'h03);
    @(negedge clk); #0.5;
    lut_in0 = 4'h0; lut_in1 = 4'h0;
    #1;
    chk("R9 latch closed low", {6'b0, q}, 8'h03);
    @(posedge clk); #0.5;
    chk("R9 latch reopens", {6'b0, q}, 8'h00);
    ce = 1'b0; lut_in0 = 4'h1; lut_in1 = 4'h1;
    #0.5;
    chk("R9 latch ce low holds", {6'b0, q}, 8'h00);
    ce = 1'b1;
    load_cfg(2'b00, 16'hAAAA, 16'hAAAA, 4'b1010, 2'b11, 2'b00, 2'b00);
    @(negedge clk); #0.5;
    lut_in0 = 4'h0; lut_in1 = 4'h1;
    #0.5;
    chk("R9 neg latch open low", {6'b0, q}, 8'h02);
    @(posedge clk); #0.5;
    lut_in0 = 4'h1; lut_in1 = 4'h0;
    #1;
    chk("R9 neg latch closed high", {6'b0, q}, 8'h02);
    step();
  endtask

  task automatic t_sync_sr();
    load_cfg(2'b00, 16'hAAAA, 16'hAAAA, 4'b0101, 2'b00, 2'b00, 2'b11);
    ce = 1'b1; lut_in0 = 4'h0; lut_in1 = 4'h0;
    step();
    chk("R10 base", {6'b0, q}, 8'h00);
    lsr = 1'b1; ce = 1'b0;
    #0.5;
    chk("R10 no force before edge", {6'b0, q}, 8'h00);
    step();
    chk("R10 set over ce", {6'b0, q}, 8'h03);
    lsr = 1'b0; ce = 1'b1;
    step();
    chk("R10 released", {6'b0, q}, 8'h00);
    load_cfg(2'b00, 16'hAAAA, 16'hAAAA, 4'b0101, 2'b00, 2'b00, 2'b00);
    lut_in0 = 4'h1; lut_in1 = 4'h1;
    step();
    chk("R10 loaded ones", {6'b0, q}, 8'h03);
    lsr = 1'b1;
    step();
    chk("R10 reset value", {6'b0, q}, 8'h00);
    lsr = 1'b0;
  endtask

  task automatic t_async_sr();
    load_cfg(2'b00, 16'hAAAA, 16'hAAAA, 4'b0101, 2'b00, 2'b11, 2'b01);
    ce = 1'b1; lut_in0 = 4'h0; lut_in1 = 4'h1;
    step();
    chk("R11 base", {6'b0, q}, 8'h02);
    lsr = 1'b1;
    #0.5;
    chk("R11 immediate force", {6'b0, q}, 8'h01);
    step();
    chk("R11 held under lsr", {6'b0, q}, 8'h01);
    lsr = 1'b0;
    step();
    chk("R11 released", {6'b0, q}, 8'h02);
    load_cfg(2'b00, 16'hAAAA, 16'hAAAA, 4'b1010, 2'b00, 2'b11, 2'b11);
    lut_in0 = 4'h0; lut_in1 = 4'h0;
    @(posedge clk); #0.5;
    chk("R11 latch base", {6'b0, q}, 8'h00);
    @(negedge clk); #0.5;
    lsr = 1'b1;
    #0.5;
    chk("R11 latch forced while closed", {6'b0, q}, 8'h03);
    lsr = 1'b0;
    #0.5;
    chk("R11 latch keeps forced", {6'b0, q}, 8'h03);
    step();
  endtask

  task automatic t_reduced();
    load_cfg(2'b00, 16'hAAAA, 16'hAAAA, 4'b0101, 2'b00, 2'b00, 2'b00);
    ce = 1'b0; lut_in0 = 4'h1; lut_in1 = 4'h1;
    #0.5;
    chk("R12 reduced follows f", {6'b0, q_r}, 8'h03);
    lsr = 1'b1; lut_in0 = 4'h0;
    #0.5;
    chk("R12 reduced ignores lsr", {6'b0, q_r}, 8'h02);
    step();
    chk("R12 reduced after edge", {6'b0, q_r}, 8'h02);
    lsr = 1'b0; ce = 1'b1;
  endtask

  initial begin
    t_reset();
    t_load_strobe();
    t_rom();
    t_ripple();
    t_cout_idle();
    t_combine();
    t_bypass();
    t_flop_pos();
    t_flop_neg();
    t_latch();
    t_sync_sr();
    t_async_sr();
    t_reduced();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      tests++;
      failed++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end
endmodule